// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits beside an instruction queue and decides, every clock cycle, which queue entries go to execution. Each entry presents a valid bit, a ready bit, a squashed bit, a class code and a sequence number. A smaller sequence number means an older entry. The block grants up to `ISSUE_W` entries per cycle. Grants go strictly oldest first. Each of the integer, floating, branch and memory classes has its own per-cycle cap. Miscellaneous entries are limited only by the total width. Squashed entries are also limited only by the total width: they may issue whether or not they are ready, so that the queue drains them.

The selection is a chain of `ISSUE_W` identical pick stages. Each stage sees the entries left over by the stages before it and the class counts gathered so far. The grants are registered, with slot 0 holding the oldest. A granted entry is masked until its valid bit drops, so the queue logic has one cycle to retire it. The block also keeps the free-slot count of the queue, raises a full flag, rejects and flags an insert made while full, and keeps issue counters for statistics.

Top module: `issue_select`

## Requirements
- R1: After reset, no grant is valid, `freed_count` is 0, `free_entries` equals `DEPTH`, `full` and `ins_err` are 0, and all statistics counters are 0.
- R2: An entry is eligible only if it is valid, ready or squashed, and not yet granted. An invalid entry or a valid entry that is neither ready nor squashed is never granted.
- R3: Grants go in ascending sequence number: slot 0 holds the oldest granted entry. On equal sequence numbers the lower entry index wins. `grant_idx` slot k occupies bits [k*IDXW +: IDXW].
- R4: Class codes are 0 integer, 1 floating, 2 branch, 3 memory and 4 miscellaneous (codes 5 to 7 act as miscellaneous). A non-squashed entry of classes 0 to 3 is granted at most the class cap per cycle. Once a class reaches its cap, younger entries of that class are skipped and older-first selection continues with other entries.
- R5: Miscellaneous entries and squashed entries of any class count only against the total width `ISSUE_W`.
- R6: Selection fills grant slots contiguously from slot 0 until `ISSUE_W` slots are used or no eligible entry remains. The grant outputs change on the clock edge that follows the inputs that produced them.
- R7: An entry that has been granted is not granted again while its valid bit stays high. Its mask clears in the first cycle its valid bit is low.
- R8: `freed_count` equals the number of valid grant slots. `free_entries` rises by the number of grants and falls by one for each accepted insert, both on the same edge.
- R9: `full` is high exactly when `free_entries` is 0. An insert request while full is not accepted: `free_entries` does not change on its account, and `ins_err` is high in the next cycle.
- R10: Each grant adds one to exactly one statistics counter. A squashed grant goes to `stat_squash`. Otherwise the grant goes to the counter for its class, with codes 4 to 7 going to `stat_misc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | DEPTH | Entry holds an instruction |
| ent_ready | input | DEPTH | Entry operands available |
| ent_squash | input | DEPTH | Entry has been squashed |
| ent_class | input | DEPTH*3 | Class code per entry, entry i at bits [3i +: 3] |
| ent_seq | input | DEPTH*SEQW | Sequence number per entry |
| ins_req | input | 1 | Insert one instruction into the queue |
| grant_valid | output | ISSUE_W | Grant slot valid |
| grant_idx | output | ISSUE_W*IDXW | Granted entry index per slot |
| freed_count | output | NW | Number of grants this cycle |
| free_entries | output | FREEW | Free queue slots |
| full | output | 1 | No free slot |
| ins_err | output | 1 | Previous cycle inserted while full |
| stat_int | output | STATW | Integer grants |
| stat_flt | output | STATW | Floating grants |
| stat_br | output | STATW | Branch grants |
| stat_mem | output | STATW | Memory grants |
| stat_misc | output | STATW | Miscellaneous grants |
| stat_squash | output | STATW | Squashed grants |

## Verification
The selector is driven with several queue images. One has all eight entries in a single capped class, which shows the cap cutting selection short of the width. One mixes classes with ages reversed against index, which separates age order from index order. One is all miscellaneous, which shows that this class has no cap. Others gate entries by ready or valid alone. One mixes squashed but not-ready entries with ready ones, to confirm that squashed entries bypass both readiness and caps. One reaches a cap while an older-first miscellaneous entry still follows, and one gives equal ages, to pin the tie-break. Holding one image for two cycles shows the granted mask at work. Filling the queue and inserting once more exercises the full flag and the insert rejection.

// File: rtl/isel_pkg.sv
package isel_pkg;

    typedef enum logic [2:0] {
        CL_INT  = 3'd0,
        CL_FLT  = 3'd1,
        CL_BR   = 3'd2,
        CL_MEM  = 3'd3,
        CL_MISC = 3'd4
    } iclass_e;

    localparam int NUM_CAPPED = 4;
    localparam int CLSW       = 3;
    localparam int NUM_STATS  = 6;
    localparam int STAT_SQ    = 5;
    localparam int STAT_MISC  = 4;

endpackage

// File: rtl/isel_pick.sv
module isel_pick #(
    parameter int DEPTH = 8,
    parameter int SEQW  = 8,
    parameter int IDXW  = 3
) (
    input  logic [DEPTH-1:0]      cand,
    input  logic [DEPTH*SEQW-1:0] seq_flat,
    output logic                  found,
    output logic [IDXW-1:0]       idx,
    output logic [DEPTH-1:0]      onehot
);

    logic [SEQW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand[i] && (!found || seq_flat[i*SEQW +: SEQW] < best)) begin
                found = 1'b1;
                idx   = IDXW'(i);
                best  = seq_flat[i*SEQW +: SEQW];
            end
        end
        onehot = found ? (DEPTH'(1) << idx) : '0;
    end

endmodule

// File: rtl/isel_select.sv
module isel_select
    import isel_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 4,
    parameter int SEQW    = 8,
    parameter int IDXW    = 3,
    parameter int CAP_INT = 2,
    parameter int CAP_FLT = 2,
    parameter int CAP_BR  = 2,
    parameter int CAP_MEM = 2
) (
    input  logic [DEPTH-1:0]        elig,
    input  logic [DEPTH-1:0]        squash,
    input  logic [DEPTH*CLSW-1:0]   cls_flat,
    input  logic [DEPTH*SEQW-1:0]   seq_flat,
    output logic [ISSUE_W-1:0]      found,
    output logic [ISSUE_W*IDXW-1:0] idx_flat,
    output logic [ISSUE_W*CLSW-1:0] pick_cls,
    output logic [ISSUE_W-1:0]      pick_sq,
    output logic [DEPTH-1:0]        taken
);

    localparam int CW  = $clog2(ISSUE_W + 1);
    localparam int CNW = NUM_CAPPED * CW;

    function automatic int cap_of(input logic [CLSW-1:0] c);
        case (c)
            CL_INT:  return CAP_INT;
            CL_FLT:  return CAP_FLT;
            CL_BR:   return CAP_BR;
            CL_MEM:  return CAP_MEM;
            default: return ISSUE_W;
        endcase
    endfunction

    function automatic logic class_open(input logic [CLSW-1:0] c,
                                        input logic [CNW-1:0] cnt);
        if (c < CLSW'(NUM_CAPPED))
            return int'(cnt[c[1:0]*CW +: CW]) < cap_of(c);
        return 1'b1;
    endfunction

    function automatic logic [CNW-1:0] bump(input logic [CNW-1:0] cnt,
                                            input logic en,
                                            input logic [CLSW-1:0] c);
        logic [CNW-1:0] r;
        r = cnt;
        if (en && c < CLSW'(NUM_CAPPED))
            r[c[1:0]*CW +: CW] = cnt[c[1:0]*CW +: CW] + CW'(1);
        return r;
    endfunction

    logic [DEPTH-1:0] avail [ISSUE_W+1];
    logic [CNW-1:0]   cnt_s [ISSUE_W+1];

    assign avail[0] = elig;
    assign cnt_s[0] = '0;

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_stage
        logic [DEPTH-1:0] cand;
        logic [DEPTH-1:0] onehot;
        logic             hit;
        logic [IDXW-1:0]  sel;
        logic [CLSW-1:0]  sel_cls;
        logic             sel_sq;

        always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
                cand[i] = avail[k][i] &
                          (squash[i] | class_open(cls_flat[i*CLSW +: CLSW], cnt_s[k]));
            end
        end

        isel_pick #(.DEPTH(DEPTH), .SEQW(SEQW), .IDXW(IDXW)) u_pick (
            .cand     (cand),
            .seq_flat (seq_flat),
            .found    (hit),
            .idx      (sel),
            .onehot   (onehot)
        );

        assign sel_cls  = cls_flat[sel*CLSW +: CLSW];
        assign sel_sq   = hit & squash[sel];

        assign avail[k+1]                  = avail[k] & ~onehot;
        assign cnt_s[k+1]                  = bump(cnt_s[k], hit & ~sel_sq, sel_cls);
        assign found[k]                    = hit;
        assign idx_flat[k*IDXW +: IDXW]    = sel;
        assign pick_cls[k*CLSW +: CLSW]    = sel_cls;
        assign pick_sq[k]                  = sel_sq;
    end

    assign taken = elig & ~avail[ISSUE_W];

endmodule

// File: rtl/isel_occupancy.sv
module isel_occupancy #(
    parameter int DEPTH = 8,
    parameter int FREEW = 4,
    parameter int NW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_req,
    input  logic [NW-1:0]    freed,
    output logic [FREEW-1:0] free_entries,
    output logic             full,
    output logic             ins_err
);

    logic [FREEW-1:0] free_q;
    logic             err_q;
    logic             accept;

    assign full   = (free_q == '0);
    assign accept = ins_req & ~full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= FREEW'(DEPTH);
            err_q  <= 1'b0;
        end else begin
            free_q <= free_q + FREEW'(freed) - FREEW'(accept);
            err_q  <= ins_req & full;
        end
    end

    assign free_entries = free_q;
    assign ins_err      = err_q;

    a_r8_free_bound : assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_q) <= DEPTH);

    a_r9_reject_full : assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && full && freed == '0) |=> (ins_err && free_q == '0));

endmodule

// File: rtl/isel_stats.sv
module isel_stats
    import isel_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int STATW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ISSUE_W-1:0]      found,
    input  logic [ISSUE_W*CLSW-1:0] pick_cls,
    input  logic [ISSUE_W-1:0]      pick_sq,
    output logic [STATW-1:0]        stat_int,
    output logic [STATW-1:0]        stat_flt,
    output logic [STATW-1:0]        stat_br,
    output logic [STATW-1:0]        stat_mem,
    output logic [STATW-1:0]        stat_misc,
    output logic [STATW-1:0]        stat_squash
);

    logic [STATW-1:0] cnt_q [NUM_STATS];
    logic [STATW-1:0] delta [NUM_STATS];

    always_comb begin
        for (int j = 0; j < NUM_STATS; j++) delta[j] = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            if (found[k]) begin
                if (pick_sq[k])
                    delta[STAT_SQ] = delta[STAT_SQ] + STATW'(1);
                else if (pick_cls[k*CLSW +: CLSW] < CLSW'(NUM_CAPPED))
                    delta[pick_cls[k*CLSW +: 2]] = delta[pick_cls[k*CLSW +: 2]] + STATW'(1);
                else
                    delta[STAT_MISC] = delta[STAT_MISC] + STATW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < NUM_STATS; j++) begin
            if (!rst_n) cnt_q[j] <= '0;
            else        cnt_q[j] <= cnt_q[j] + delta[j];
        end
    end

    assign stat_int    = cnt_q[0];
    assign stat_flt    = cnt_q[1];
    assign stat_br     = cnt_q[2];
    assign stat_mem    = cnt_q[3];
    assign stat_misc   = cnt_q[STAT_MISC];
    assign stat_squash = cnt_q[STAT_SQ];

endmodule

// File: rtl/issue_select.sv
module issue_select
    import isel_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 4,
    parameter int SEQW    = 8,
    parameter int CAP_INT = 2,
    parameter int CAP_FLT = 2,
    parameter int CAP_BR  = 2,
    parameter int CAP_MEM = 2,
    parameter int STATW   = 16,
    localparam int IDXW   = $clog2(DEPTH),
    localparam int FREEW  = $clog2(DEPTH + 1),
    localparam int NW     = $clog2(ISSUE_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEPTH-1:0]        ent_valid,
    input  logic [DEPTH-1:0]        ent_ready,
    input  logic [DEPTH-1:0]        ent_squash,
    input  logic [DEPTH*3-1:0]      ent_class,
    input  logic [DEPTH*SEQW-1:0]   ent_seq,
    input  logic                    ins_req,
    output logic [ISSUE_W-1:0]      grant_valid,
    output logic [ISSUE_W*IDXW-1:0] grant_idx,
    output logic [NW-1:0]           freed_count,
    output logic [FREEW-1:0]        free_entries,
    output logic                    full,
    output logic                    ins_err,
    output logic [STATW-1:0]        stat_int,
    output logic [STATW-1:0]        stat_flt,
    output logic [STATW-1:0]        stat_br,
    output logic [STATW-1:0]        stat_mem,
    output logic [STATW-1:0]        stat_misc,
    output logic [STATW-1:0]        stat_squash
);

    logic [DEPTH-1:0]        issued_q;
    logic [DEPTH-1:0]        elig;
    logic [DEPTH-1:0]        taken;
    logic [ISSUE_W-1:0]      found;
    logic [ISSUE_W*IDXW-1:0] idx_flat;
    logic [ISSUE_W*CLSW-1:0] pick_cls;
    logic [ISSUE_W-1:0]      pick_sq;
    logic [NW-1:0]           freed_now;

    logic [ISSUE_W-1:0]      gvalid_q;
    logic [ISSUE_W*IDXW-1:0] gidx_q;
    logic [NW-1:0]           freed_q;

    assign elig = ent_valid & (ent_ready | ent_squash) & ~issued_q;

    isel_select #(
        .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .SEQW(SEQW), .IDXW(IDXW),
        .CAP_INT(CAP_INT), .CAP_FLT(CAP_FLT), .CAP_BR(CAP_BR), .CAP_MEM(CAP_MEM)
    ) u_select (
        .elig     (elig),
        .squash   (ent_squash),
        .cls_flat (ent_class),
        .seq_flat (ent_seq),
        .found    (found),
        .idx_flat (idx_flat),
        .pick_cls (pick_cls),
        .pick_sq  (pick_sq),
        .taken    (taken)
    );

    always_comb begin
        freed_now = '0;
        for (int k = 0; k < ISSUE_W; k++) freed_now = freed_now + NW'(found[k]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_q <= '0;
            gvalid_q <= '0;
            gidx_q   <= '0;
            freed_q  <= '0;
        end else begin
            issued_q <= ent_valid & (issued_q | taken);
            gvalid_q <= found;
            gidx_q   <= idx_flat;
            freed_q  <= freed_now;
        end
    end

    assign grant_valid = gvalid_q;
    assign grant_idx   = gidx_q;
    assign freed_count = freed_q;

    isel_occupancy #(.DEPTH(DEPTH), .FREEW(FREEW), .NW(NW)) u_occ (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_req      (ins_req),
        .freed        (freed_now),
        .free_entries (free_entries),
        .full         (full),
        .ins_err      (ins_err)
    );

    isel_stats #(.ISSUE_W(ISSUE_W), .STATW(STATW)) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .found       (found),
        .pick_cls    (pick_cls),
        .pick_sq     (pick_sq),
        .stat_int    (stat_int),
        .stat_flt    (stat_flt),
        .stat_br     (stat_br),
        .stat_mem    (stat_mem),
        .stat_misc   (stat_misc),
        .stat_squash (stat_squash)
    );

    // Checker state: class, squash and age of what each slot granted.
    logic [ISSUE_W*CLSW-1:0] chk_cls_q;
    logic [ISSUE_W-1:0]      chk_sq_q;
    logic [ISSUE_W*SEQW-1:0] chk_seq_q;
    logic                    cap_viol;
    logic                    order_viol;
    logic                    dup_viol;

    always_ff @(posedge clk) begin
        chk_cls_q <= pick_cls;
        chk_sq_q  <= pick_sq;
        for (int k = 0; k < ISSUE_W; k++)
            chk_seq_q[k*SEQW +: SEQW] <= ent_seq[idx_flat[k*IDXW +: IDXW]*SEQW +: SEQW];
    end

    always_comb begin
        int n;
        cap_viol   = 1'b0;
        order_viol = 1'b0;
        dup_viol   = 1'b0;
        for (int c = 0; c < NUM_CAPPED; c++) begin
            n = 0;
            for (int k = 0; k < ISSUE_W; k++)
                if (gvalid_q[k] && !chk_sq_q[k] && chk_cls_q[k*CLSW +: CLSW] == CLSW'(c)) n++;
            if ((c == 0 && n > CAP_INT) || (c == 1 && n > CAP_FLT) ||
                (c == 2 && n > CAP_BR)  || (c == 3 && n > CAP_MEM)) cap_viol = 1'b1;
        end
        for (int k = 0; k + 1 < ISSUE_W; k++)
            if (gvalid_q[k+1] && chk_seq_q[k*SEQW +: SEQW] > chk_seq_q[(k+1)*SEQW +: SEQW])
                order_viol = 1'b1;
        for (int a = 0; a < ISSUE_W; a++)
            for (int b = a + 1; b < ISSUE_W; b++)
                if (gvalid_q[a] && gvalid_q[b] &&
                    gidx_q[a*IDXW +: IDXW] == gidx_q[b*IDXW +: IDXW]) dup_viol = 1'b1;
    end

    a_r6_packed_slots : assert property (@(posedge clk) disable iff (!rst_n)
        (ISSUE_W'(grant_valid + 1'b1) & grant_valid) == '0);

    a_r4_class_cap : assert property (@(posedge clk) disable iff (!rst_n)
        !cap_viol);

    a_r3_age_order : assert property (@(posedge clk) disable iff (!rst_n)
        !order_viol);

    a_r7_no_duplicate : assert property (@(posedge clk) disable iff (!rst_n)
        !dup_viol);

    a_r8_freed_matches : assert property (@(posedge clk) disable iff (!rst_n)
        int'(freed_count) == $countones(grant_valid));

endmodule

// File: tb/issue_select_test.sv
`timescale 1ns/1ps
module issue_select_test;

    localparam int DEPTH = 8;
    localparam int W     = 4;
    localparam int SEQW  = 8;

    typedef struct packed {
        logic [7:0]  v;
        logic [7:0]  r;
        logic [7:0]  s;
        logic [23:0] cls;
        logic [63:0] seq;
        logic [2:0]  n;
        logic [11:0] idx;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        // single class, int cap 2
        '{8'hFF, 8'hFF, 8'h00, 24'h0,
          {8'd17,8'd16,8'd15,8'd14,8'd13,8'd12,8'd11,8'd10}, 3'd2, {3'd0,3'd0,3'd1,3'd0}},
        // mixed classes, ages reversed against index
        '{8'hFF, 8'hFF, 8'h00, {3'd3,3'd2,3'd1,3'd0,3'd3,3'd2,3'd1,3'd0},
          {8'd10,8'd20,8'd30,8'd40,8'd50,8'd60,8'd70,8'd80}, 3'd4, {3'd4,3'd5,3'd6,3'd7}},
        // all misc, scrambled ages
        '{8'hFF, 8'hFF, 8'h00, {8{3'd4}},
          {8'd40,8'd80,8'd30,8'd60,8'd10,8'd70,8'd20,8'd50}, 3'd4, {3'd7,3'd5,3'd1,3'd3}},
        // ready gating
        '{8'hFF, 8'h44, 8'h00, 24'h0,
          {8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1,8'd0}, 3'd2, {3'd0,3'd0,3'd6,3'd2}},
        // squashed bypass ready and cap
        '{8'hFF, 8'h18, 8'h07, 24'h0,
          {8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1,8'd0}, 3'd4, {3'd3,3'd2,3'd1,3'd0}},
        // valid gating
        '{8'h00, 8'hFF, 8'h00, 24'h0,
          {8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1,8'd0}, 3'd0, 12'h0},
        // mem cap then misc
        '{8'h1F, 8'h1F, 8'h00, {3'd0,3'd0,3'd0,3'd4,3'd3,3'd3,3'd3,3'd3},
          {8'd0,8'd0,8'd0,8'd9,8'd4,8'd3,8'd2,8'd1}, 3'd3, {3'd0,3'd4,3'd1,3'd0}},
        // float cap interleaved with branch
        '{8'h3F, 8'h3F, 8'h00, {3'd0,3'd0,3'd2,3'd2,3'd2,3'd1,3'd1,3'd1},
          {8'd0,8'd0,8'd3,8'd9,8'd8,8'd7,8'd6,8'd5}, 3'd4, {3'd3,3'd1,3'd0,3'd5}},
        // equal ages, lower index first
        '{8'h24, 8'h24, 8'h00, {8{3'd4}},
          {8{8'd7}}, 3'd2, {3'd0,3'd0,3'd5,3'd2}}
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [DEPTH-1:0]     ent_valid, ent_ready, ent_squash;
    logic [DEPTH*3-1:0]   ent_class;
    logic [DEPTH*SEQW-1:0] ent_seq;
    logic                 ins_req;
    logic [W-1:0]         grant_valid;
    logic [W*3-1:0]       grant_idx;
    logic [2:0]           freed_count;
    logic [3:0]           free_entries;
    logic                 full, ins_err;
    logic [15:0]          stat_int, stat_flt, stat_br, stat_mem, stat_misc, stat_squash;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    issue_select uut (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_squash(ent_squash),
        .ent_class(ent_class), .ent_seq(ent_seq), .ins_req(ins_req),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .freed_count(freed_count),
        .free_entries(free_entries), .full(full), .ins_err(ins_err),
        .stat_int(stat_int), .stat_flt(stat_flt), .stat_br(stat_br),
        .stat_mem(stat_mem), .stat_misc(stat_misc), .stat_squash(stat_squash)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int stat_sum();
        return int'(stat_int) + int'(stat_flt) + int'(stat_br) +
               int'(stat_mem) + int'(stat_misc) + int'(stat_squash);
    endfunction

    task automatic idle_inputs();
        ent_valid = '0; ent_ready = '0; ent_squash = '0;
        ent_class = '0; ent_seq = '0; ins_req = 1'b0;
    endtask

    task automatic fill_queue();
        while (!full) begin
            ins_req = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        ins_req = 1'b0;
    endtask

    task automatic apply_vec(input vec_t t);
        ent_valid = t.v; ent_ready = t.r; ent_squash = t.s;
        ent_class = t.cls; ent_seq = t.seq;
    endtask

    task automatic check_grants(input vec_t t, input string tag);
        int exp_gv;
        exp_gv = (1 << int'(t.n)) - 1;
        chk({tag, " R2 R4 R5 R6 grant pattern"}, int'(grant_valid), exp_gv);
        for (int k = 0; k < int'(t.n); k++)
            chk({tag, " R3 grant slot index"}, int'(grant_idx[k*3 +: 3]), int'(t.idx[k*3 +: 3]));
        chk({tag, " R8 freed count"}, int'(freed_count), int'(t.n));
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int base, sq0;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 grant_valid", int'(grant_valid), 0);
        chk("R1 freed_count", int'(freed_count), 0);
        chk("R1 free_entries", int'(free_entries), DEPTH);
        chk("R1 full", int'(full), 0);
        chk("R1 ins_err", int'(ins_err), 0);
        chk("R1 stats", stat_sum(), 0);

        // R9 fill to full, then insert once more
        fill_queue();
        chk("R9 full after fill", int'(full), 1);
        ins_req = 1'b1;
        @(posedge clk); @(negedge clk);
        ins_req = 1'b0;
        chk("R9 ins_err after insert while full", int'(ins_err), 1);
        chk("R9 free unchanged", int'(free_entries), 0);
        @(posedge clk); @(negedge clk);
        chk("R9 ins_err clears", int'(ins_err), 0);

        // vector table
        for (int vi = 0; vi < NV; vi++) begin
            fill_queue();
            base = stat_sum();
            sq0  = int'(stat_squash);
            apply_vec(VEC[vi]);
            @(posedge clk); @(negedge clk);
            check_grants(VEC[vi], $sformatf("vec%0d", vi));
            chk("R8 free rises by grants", int'(free_entries), int'(VEC[vi].n));
            chk("R9 full tracks free", int'(full), int'(VEC[vi].n == 0));
            chk("R10 stats total", stat_sum() - base, int'(VEC[vi].n));
            if (vi == 4) chk("R10 squashed counter", int'(stat_squash) - sq0, 3);
            idle_inputs();
            @(posedge clk); @(negedge clk);
            chk("R6 no grants when idle", int'(grant_valid), 0);
        end

        // R7 hold the first image two cycles: second cycle takes the next two
        fill_queue();
        apply_vec(VEC[0]);
        @(posedge clk); @(negedge clk);
        chk("R7 first cycle slot0", int'(grant_idx[2:0]), 0);
        @(posedge clk); @(negedge clk);
        chk("R7 second cycle count", int'(grant_valid), 3);
        chk("R7 second cycle slot0", int'(grant_idx[2:0]), 2);
        chk("R7 second cycle slot1", int'(grant_idx[5:3]), 3);
        chk("R8 free after two cycles", int'(free_entries), 4);
        chk("R10 int counter", int'(stat_int) >= 4 ? 1 : 0, 1);
        idle_inputs();
        @(posedge clk); @(negedge clk);

        // R8 insert and issue on the same edge
        ins_req = 1'b1;
        apply_vec(VEC[3]);
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("R8 insert plus two grants", int'(free_entries), 4 + 2 - 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule